// File: doc/BRIEF.md
# Flash Region Write Protection Unit

This block guards the erase and write command path of an on-chip flash controller. The flash is split into 4 kB blocks, and each block has one protection flag. Software sets these flags through two 32-bit configuration registers. A flag, once set, stays set until the next device reset. Every page-erase or word-write request that passes through the guard is checked against the flag of the block it addresses. Any such request that hits a protected block is dropped, and a one-cycle fault pulse goes to the CPU in its place. A full-chip erase is refused while any flag is set.

Requests use a valid/ready stream on both sides. An accepted request is forwarded to the controller unchanged, in the same cycle. Back-pressure works as follows. Upstream ready follows downstream ready when a request is allowed through. Upstream ready is forced high when a request is refused, so the refused request is consumed and discarded. The forwarded valid never depends on downstream ready.

A debug-disable register defaults to 1. While it holds 1 and the debug-active pin is high, every check is suspended. Writing 0 to it keeps protection in force even while a debugger is attached.

Top module: `flash_wp_guard`

## Requirements
- R1: Flag i protects byte addresses i*4096 to i*4096+4095. Flags 0..31 are bits 0..31 of the register at offset 0x600, and flags 32..47 are bits 0..15 of the register at offset 0x604.
- R2: A register write sets each flag whose data bit is 1. A data bit of 0 leaves the flag unchanged, so the stored value becomes old OR data.
- R3: All flags reset to 0. No register write clears a flag.
- R4: Bits 31:16 of offset 0x604 read as 0. Bits 31:1 of offset 0x608 read as 0. Offset 0x60C reads as 0, and writes to it change nothing.
- R5: A request of kind 0 (page erase), kind 1 (word write) or kind 3 (treated as a write) whose block is protected is refused in its own cycle: out_valid=0, fault=1 and in_ready=1.
- R6: A request of kind 2 (chip erase) is refused with a fault whenever at least one flag is set, whatever its address. With no flag set it is forwarded.
- R7: The debug-disable register at offset 0x608 resets to 1. While it is 1 and dbg_active is 1, no request is refused.
- R8: While the debug-disable register is 0, requests are checked whatever the level of dbg_active.
- R9: A request that is not refused is forwarded: out_valid=in_valid, out_kind/out_addr/out_data equal the inputs, and in_ready=out_ready. Addresses at or above 0x30000 with kinds 0, 1 or 3 are always forwarded.
- R10: Read data appears on reg_rdata in the cycle after reg_rd_en. In a cycle that follows no read, reg_rdata is 0.
- R11: A request in the same cycle as a register write that sets its flag is judged by the flags as they were before the write.
- R12: fault is high only in a cycle where in_valid is high and the request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| dbg_active | input | 1 | A debugger is attached |
| in_valid | input | 1 | Upstream request valid |
| in_ready | output | 1 | Upstream request accepted |
| in_kind | input | 2 | 0 page erase, 1 word write, 2 chip erase, 3 write |
| in_addr | input | 20 | Flash byte address |
| in_data | input | 32 | Write data |
| out_valid | output | 1 | Forwarded request valid |
| out_ready | input | 1 | Flash controller ready |
| out_kind | output | 2 | Forwarded kind |
| out_addr | output | 20 | Forwarded address |
| out_data | output | 32 | Forwarded data |
| fault | output | 1 | Single-cycle refusal pulse |

## Verification
Two functions can fall in one cycle: a register write that sets a flag, and a request aimed at the block that flag guards. The bench provokes this by driving both on one clock edge. It checks the combinational response before that edge, where the request must still pass. It then repeats the request after the edge, where the request must be refused. Every block index, plus two indices past the top, is swept with every request kind, under both polarities of downstream ready and in several debug states.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    REQ_PAGE_ERASE = 2'd0,
    REQ_WORD_WRITE = 2'd1,
    REQ_CHIP_ERASE = 2'd2,
    REQ_WRITE_ALT  = 2'd3
  } req_kind_e;

  localparam int REG_ADDR_W = 12;
  localparam int CFG_BASE   = 'h600;
endpackage

// File: rtl/fwp_regs.sv
module fwp_regs
  import fwp_pkg::*;
#(
  parameter int NUM_BLOCKS = 48,
  parameter int REG_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      rdata,
  output logic [NUM_BLOCKS-1:0] prot,
  output logic                  dbg_dis
);
  localparam int NUM_CFG = (NUM_BLOCKS + REG_W - 1) / REG_W;
  localparam int DBG_OFF = CFG_BASE + 4 * NUM_CFG;
  localparam int PAD_W   = NUM_CFG * REG_W;

  // sticky flags: set by a 1 in the matching data bit, cleared only by reset
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_flag
    localparam int RIDX = i / REG_W;
    localparam int BIDX = i % REG_W;
    localparam logic [REG_ADDR_W-1:0] OFF = REG_ADDR_W'(CFG_BASE + 4 * RIDX);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             prot[i] <= 1'b0;
      else if (wr_en && addr == OFF && wdata[BIDX]) prot[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_dis <= 1'b1;
    else if (wr_en && addr == REG_ADDR_W'(DBG_OFF)) dbg_dis <= wdata[0];
  end

  logic [PAD_W-1:0] prot_pad;
  assign prot_pad = PAD_W'(prot);

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CFG; k++) begin
      if (addr == REG_ADDR_W'(CFG_BASE + 4 * k)) rd_mux = prot_pad[k*REG_W +: REG_W];
    end
    if (addr == REG_ADDR_W'(DBG_OFF)) rd_mux = {{(REG_W-1){1'b0}}, dbg_dis};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_mux : '0;
  end
endmodule

// File: rtl/fwp_decode.sv
module fwp_decode #(
  parameter int NUM_BLOCKS = 48,
  parameter int ADDR_W     = 20,
  parameter int BLK_LOG2   = 12
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_BLOCKS-1:0] prot,
  output logic                  hit,
  output logic                  any_prot
);
  localparam int IDX_W = ADDR_W - BLK_LOG2;
  localparam int PAD_N = 1 << IDX_W;

  logic [IDX_W-1:0] idx;
  logic [PAD_N-1:0] pad;

  assign idx      = addr[ADDR_W-1:BLK_LOG2];
  // indices past the last block land on zero padding and never hit
  assign pad      = PAD_N'(prot);
  assign hit      = pad[idx];
  assign any_prot = |prot;
endmodule

// File: rtl/fwp_gate.sv
module fwp_gate
  import fwp_pkg::*;
(
  input  logic      in_valid,
  input  req_kind_e kind,
  input  logic      hit,
  input  logic      any_prot,
  input  logic      bypass,
  input  logic      out_ready,
  output logic      out_valid,
  output logic      in_ready,
  output logic      fault
);
  logic refuse;

  always_comb begin
    unique case (kind)
      REQ_CHIP_ERASE: refuse = any_prot;
      default:        refuse = hit;
    endcase
    if (bypass) refuse = 1'b0;
  end

  assign out_valid = in_valid & ~refuse;
  assign in_ready  = refuse | out_ready;
  assign fault     = in_valid & refuse;
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
  import fwp_pkg::*;
#(
  parameter int NUM_BLOCKS = 48,
  parameter int ADDR_W     = 20,
  parameter int BLK_LOG2   = 12,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dbg_active,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              fault
);
  logic [NUM_BLOCKS-1:0] prot_q;
  logic                  dbg_dis_q;
  logic                  blk_hit;
  logic                  any_prot;

  fwp_regs #(.NUM_BLOCKS(NUM_BLOCKS), .REG_W(32)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .rd_en  (reg_rd_en),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .prot   (prot_q),
    .dbg_dis(dbg_dis_q)
  );

  fwp_decode #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)) u_dec (
    .addr    (in_addr),
    .prot    (prot_q),
    .hit     (blk_hit),
    .any_prot(any_prot)
  );

  fwp_gate u_gate (
    .in_valid (in_valid),
    .kind     (req_kind_e'(in_kind)),
    .hit      (blk_hit),
    .any_prot (any_prot),
    .bypass   (dbg_active & dbg_dis_q),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .in_ready (in_ready),
    .fault    (fault)
  );

  assign out_kind = in_kind;
  assign out_addr = in_addr;
  assign out_data = in_data;
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int NUM_BLOCKS = 48,
  parameter int ADDR_W     = 20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_rd_en,
  input logic [11:0]           reg_addr,
  input logic [31:0]           reg_rdata,
  input logic                  dbg_active,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [ADDR_W-1:0]     in_addr,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [ADDR_W-1:0]     out_addr,
  input logic                  fault,
  input logic [NUM_BLOCKS-1:0] prot_q,
  input logic                  dbg_dis_q
);
  // R3: a set flag never falls outside reset
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(prot_q) & ~prot_q) == '0));

  // R5: a refused request is never forwarded and is consumed
  a_r5_fault_drops: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!out_valid && in_ready));

  // R7: bypass in debug suppresses every fault
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && dbg_dis_q) |-> !fault);

  // R9: forwarded requests carry the same address and follow downstream ready
  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr == in_addr && in_ready == out_ready && in_valid));

  // R10: read data is zero after a cycle without a read
  a_r10_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd_en) |-> reg_rdata == 32'd0);

  // R4: upper half of the second config register reads zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rd_en) && $past(reg_addr) == 12'h604) |-> reg_rdata[31:16] == 16'd0);

  // R12: fault only with a valid request
  a_r12_fault_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> in_valid);
endmodule

bind flash_wp_guard fwp_checker #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .dbg_active(dbg_active),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_addr   (in_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .fault     (fault),
  .prot_q    (prot_q),
  .dbg_dis_q (dbg_dis_q)
);

// File: tb/test_flash_wp_guard.sv
module test_flash_wp_guard;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr_en = 0, reg_rd_en = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_active = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [1:0]  in_kind = '0;
  logic [19:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [1:0]  out_kind;
  logic [19:0] out_addr;
  logic [31:0] out_data;
  logic        fault;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [47:0] model = '0;
  bit model_dis = 1;

  always #5 clk = ~clk;

  flash_wp_guard i_flash_wp_guard (.*);

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_rd_en = 1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 0;
    check(tag, reg_rdata, exp);
  endtask

  function automatic bit refused(int blk, int k);
    if (dbg_active && model_dis) return 0;
    if (k == 2) return |model;
    return (blk < 48) ? model[blk] : 1'b0;
  endfunction

  task automatic req_check(string tag, int blk, int k, logic [11:0] off, bit ordy);
    bit r;
    @(negedge clk);
    in_valid = 1; in_kind = 2'(k); in_addr = 20'(blk * 4096 + off);
    in_data = 32'(blk * 131 + k); out_ready = ordy;
    #1;
    r = refused(blk, k);
    check({tag, " fault"}, 32'(fault), 32'(r));
    check({tag, " out_valid"}, 32'(out_valid), 32'(!r));
    check({tag, " in_ready"}, 32'(in_ready), r ? 32'd1 : 32'(ordy));
    if (!r) check({tag, " fwd"}, {out_kind, out_addr, 10'd0}, {2'(k), in_addr, 10'd0});
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic sweep(string tag);
    for (int b = 0; b < 50; b++)
      for (int k = 0; k < 4; k++)
        req_check(tag, b, k, (b % 2) ? 12'hFFF : 12'(b * 52), 1'((b + k) % 2));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 R7 R10: reset state
    check("R12 reset fault", 32'(fault), 0);
    check("R10 idle rdata", reg_rdata, 0);
    rd_check("R3 reset cfg0", 12'h600, 0);
    rd_check("R3 reset cfg1", 12'h604, 0);
    rd_check("R7 reset dbgdis", 12'h608, 1);
    // R6: chip erase passes with no flag set
    req_check("R6 chip clear", 5, 2, 12'h0, 1);
    // R2 R1: set flags, zeros have no effect
    wr(12'h600, 32'h8000_0005); model[31:0] |= 32'h8000_0005;
    wr(12'h600, 32'h0000_0000);
    wr(12'h600, 32'h0010_0000); model[31:0] |= 32'h0010_0000;
    wr(12'h604, 32'hFFFF_8001); model[47:32] |= 16'h8001;
    rd_check("R2 cfg0 or", 12'h600, model[31:0]);
    rd_check("R4 cfg1 upper", 12'h604, {16'd0, model[47:32]});
    // R4: reserved offset
    wr(12'h60C, 32'hFFFF_FFFF);
    rd_check("R4 rsvd", 12'h60C, 0);
    rd_check("R4 cfg0 after rsvd", 12'h600, model[31:0]);
    wr(12'h608, 32'hFFFF_FFFE); model_dis = 0;
    rd_check("R4 dbg upper", 12'h608, 0);
    wr(12'h608, 32'h1); model_dis = 1;
    rd_check("R7 dbg set", 12'h608, 1);
    // R1 R5 R6 R9: full sweep, no debug
    sweep("R5 sweep");
    // R7: bypass in debug
    dbg_active = 1;
    sweep("R7 bypass");
    // R8: protection kept in debug
    wr(12'h608, 32'h0); model_dis = 0;
    sweep("R8 dbg kept");
    dbg_active = 0;
    // R11: write and request in same cycle
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 12'h600; reg_wdata = 32'h0000_0200;
    in_valid = 1; in_kind = 2'd1; in_addr = 20'(9 * 4096 + 8); out_ready = 1;
    #1;
    check("R11 pre-write pass", 32'(out_valid), 1);
    check("R11 pre-write fault", 32'(fault), 0);
    @(negedge clk);
    reg_wr_en = 0;
    #1;
    model[9] = 1'b1;
    check("R11 post-write fault", 32'(fault), 1);
    check("R11 post-write out_valid", 32'(out_valid), 0);
    @(negedge clk);
    in_valid = 0;
    // R3: no write clears
    wr(12'h600, 32'h0); wr(12'h604, 32'h0);
    rd_check("R3 sticky cfg0", 12'h600, model[31:0]);
    rd_check("R3 sticky cfg1", 12'h604, {16'd0, model[47:32]});
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule